// File: doc/BRIEF.md
# MDIO Management Slave

This block is the serial management slave of an Ethernet PHY. It runs on the management clock and samples the bidirectional data line on each rising edge. It decodes management frames: a run of at least 32 ones, the start pattern `01`, a two-bit opcode, a five-bit device address and a five-bit register address. A read frame addressed to this device is answered by driving the line. A write frame updates a small bank of 16-bit registers.

The device address is fixed as `00AAA`, where `AAA` comes from three strap inputs. A strap value of zero disables the slave. The live status word and the link partner word come from input ports, and two identifier words are parameters. Event inputs set sticky interrupt status bits. Each status bit that has its matching enable bit set asserts the interrupt output.

The line is modelled as separate input, output and output-enable signals, so the pad sits outside the block.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset, `mdio_oe` and `irq` are low. Register 0 reads `CTRL_RST`, register 4 reads `ADV_RST`, and registers 22 and 23 read zero.
- R2: Registers 0 (control) and 4 (advertisement) store all 16 written bits. Register 22 (interrupt enable) keeps only its low `IRQ_W` bits and reads zero above them.
- R3: On a read frame the slave leaves the first turnaround bit undriven. It then drives `mdio_oe` for exactly 17 bit periods: the second turnaround bit as 0, followed by 16 data bits with the most significant bit first. Each new value appears after a rising edge, so the master can sample it on the following rising edge.
- R4: Register 1 returns the `phy_status` input and register 5 returns the `partner_ability` input, both sampled when the frame header completes. Registers 2 and 3 return `ID_HI` and `ID_LO`. Writes to these four registers are discarded.
- R5: Every register address other than 0–5, 22 and 23 reads zero, and writes to such an address are discarded.
- R6: Only the device address `{2'b00, strap_addr}` is accepted, and only when `strap_addr` is nonzero. For any other address the slave never drives the line and ignores write data.
- R7: The opcode `10` means read and `01` means write. A frame carrying `00` or `11` is ignored and is never driven.
- R8: A frame preceded by fewer than 32 ones is ignored. A run of exactly 32 ones, or any longer run, is accepted.
- R9: Each event input bit sampled high on a rising edge sets bit b of register 23, and that bit stays set. `irq` is high exactly when some bit is set in both register 22 and register 23.
- R10: A read of register 23 returns the latched bits and then clears them, so a second read returns zero and `irq` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Value seen on the management data line |
| mdio_out | output | 1 | Value driven onto the line while `mdio_oe` is high |
| mdio_oe | output | 1 | Output enable for the line driver |
| strap_addr | input | 3 | Low three bits of the device address (0 disables the slave) |
| phy_status | input | 16 | Live status word read at register 1 |
| partner_ability | input | 16 | Link partner word read at register 5 |
| irq_event | input | IRQ_W | Event inputs that set interrupt status bits |
| irq | output | 1 | Interrupt request, active high |

## Verification
Four properties are checked on every cycle:
- The output-enable window never exceeds 17 cycles, and every window that closes lasts exactly 17 cycles.
- The first driven bit of each window is 0.
- The line is never driven while the strap value is zero.
- A status bit only drops after a read of register 23, and the interrupt only rises after an event or a write.

The bench scenarios cover what needs the whole frame:
- the data values returned for each register, and the discarding of writes to read-only or absent registers;
- silence toward each of the 31 foreign addresses and toward the two invalid opcodes;
- the boundary between 31 and 32 preamble ones;
- the per-bit interplay of enable, status and clear-on-read.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
    localparam int DATA_W = 16;
    localparam int REG_AW = 5;
    localparam int HDR_W  = 2 + 2 * REG_AW;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam logic [REG_AW-1:0] REG_CTRL    = 5'd0;
    localparam logic [REG_AW-1:0] REG_STAT    = 5'd1;
    localparam logic [REG_AW-1:0] REG_ID_HI   = 5'd2;
    localparam logic [REG_AW-1:0] REG_ID_LO   = 5'd3;
    localparam logic [REG_AW-1:0] REG_ADV     = 5'd4;
    localparam logic [REG_AW-1:0] REG_PARTNER = 5'd5;
    localparam logic [REG_AW-1:0] REG_IRQ_EN  = 5'd22;
    localparam logic [REG_AW-1:0] REG_IRQ_ST  = 5'd23;

    typedef enum logic [2:0] {
        F_PRE,
        F_START,
        F_HDR,
        F_RTA1,
        F_RTA2,
        F_RDATA,
        F_WTA,
        F_WDATA
    } frame_st_e;
endpackage

// File: rtl/mgmt_frame_fsm.sv
`timescale 1ns/1ps
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [2:0]        strap_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_req,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int CLOG_PRE = $clog2(PRE_LEN + 1);
    localparam int CNT_W    = (CLOG_PRE > 5) ? CLOG_PRE : 5;
    localparam logic [CNT_W-1:0] PRE_MAX  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [REG_AW-1:0] wreg;
        logic [DATA_W-1:0] sh;
        logic              out;
        logic              oe;
    } fsm_s;

    fsm_s q, d;

    logic [HDR_W-1:0]  hdr_nx;
    logic [1:0]        op_nx;
    logic [REG_AW-1:0] dev_nx;
    logic              addr_hit;

    assign hdr_nx   = {q.hdr[HDR_W-2:0], mdio_in};
    assign op_nx    = hdr_nx[HDR_W-1 -: 2];
    assign dev_nx   = hdr_nx[2*REG_AW-1 -: REG_AW];
    assign addr_hit = (strap_addr != 3'd0) && (dev_nx == {2'b00, strap_addr});

    assign rd_addr  = hdr_nx[REG_AW-1:0];
    assign wr_addr  = q.wreg;
    assign wr_data  = {q.sh[DATA_W-2:0], mdio_in};
    assign mdio_out = q.out;
    assign mdio_oe  = q.oe;

    always_comb begin
        d      = q;
        rd_req = 1'b0;
        wr_req = 1'b0;
        case (q.st)
            F_PRE: begin
                if (mdio_in) begin
                    if (q.cnt < PRE_MAX) d.cnt = q.cnt + 1'b1;
                end else if (q.cnt >= PRE_MAX) begin
                    d.st  = F_START;
                    d.cnt = '0;
                end else begin
                    d.cnt = '0;
                end
            end
            F_START: begin
                d.cnt = '0;
                d.st  = mdio_in ? F_HDR : F_PRE;
            end
            F_HDR: begin
                d.hdr = hdr_nx;
                if (q.cnt == HDR_LAST) begin
                    d.cnt = '0;
                    if (addr_hit && op_nx == OP_READ) begin
                        rd_req = 1'b1;
                        d.sh   = rd_data;
                        d.st   = F_RTA1;
                    end else if (addr_hit && op_nx == OP_WRITE) begin
                        d.wreg = hdr_nx[REG_AW-1:0];
                        d.st   = F_WTA;
                    end else begin
                        d.st = F_PRE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            F_RTA1: begin
                d.oe  = 1'b1;
                d.out = 1'b0;
                d.st  = F_RTA2;
            end
            F_RTA2: begin
                d.out = q.sh[DATA_W-1];
                d.sh  = {q.sh[DATA_W-2:0], 1'b0};
                d.cnt = '0;
                d.st  = F_RDATA;
            end
            F_RDATA: begin
                if (q.cnt == DAT_LAST) begin
                    d.oe  = 1'b0;
                    d.out = 1'b0;
                    d.cnt = '0;
                    d.st  = F_PRE;
                end else begin
                    d.out = q.sh[DATA_W-1];
                    d.sh  = {q.sh[DATA_W-2:0], 1'b0};
                    d.cnt = q.cnt + 1'b1;
                end
            end
            F_WTA: begin
                if (q.cnt == CNT_W'(1)) begin
                    d.cnt = '0;
                    d.st  = F_WDATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            F_WDATA: begin
                d.sh = wr_data;
                if (q.cnt == DAT_LAST) begin
                    wr_req = 1'b1;
                    d.cnt  = '0;
                    d.st   = F_PRE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st  = F_PRE;
                d.cnt = '0;
                d.oe  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= F_PRE;
            q.cnt  <= '0;
            q.hdr  <= '0;
            q.wreg <= '0;
            q.sh   <= '0;
            q.out  <= 1'b0;
            q.oe   <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mgmt_reg_bank.sv
`timescale 1ns/1ps
module mgmt_reg_bank
    import mgmt_pkg::*;
#(
    parameter int          IRQ_W    = 8,
    parameter logic [15:0] CTRL_RST = 16'h1100,
    parameter logic [15:0] ADV_RST  = 16'h01E1,
    parameter logic [15:0] ID_HI    = 16'h0022,
    parameter logic [15:0] ID_LO    = 16'h1615
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] phy_status,
    input  logic [DATA_W-1:0] partner_ability,
    input  logic [IRQ_W-1:0]  irq_event,
    output logic [IRQ_W-1:0]  irq_en,
    output logic [IRQ_W-1:0]  irq_status
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] adv;
        logic [IRQ_W-1:0]  ie;
        logic [IRQ_W-1:0]  is;
    } bank_s;

    bank_s q, d;
    logic  clr_hit;

    assign clr_hit    = rd_req && (rd_addr == REG_IRQ_ST);
    assign irq_en     = q.ie;
    assign irq_status = q.is;

    always_comb begin
        case (rd_addr)
            REG_CTRL:    rd_data = q.ctrl;
            REG_STAT:    rd_data = phy_status;
            REG_ID_HI:   rd_data = ID_HI;
            REG_ID_LO:   rd_data = ID_LO;
            REG_ADV:     rd_data = q.adv;
            REG_PARTNER: rd_data = partner_ability;
            REG_IRQ_EN:  rd_data = DATA_W'(q.ie);
            REG_IRQ_ST:  rd_data = DATA_W'(q.is);
            default:     rd_data = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (wr_req) begin
            case (wr_addr)
                REG_CTRL:   d.ctrl = wr_data;
                REG_ADV:    d.adv  = wr_data;
                REG_IRQ_EN: d.ie   = wr_data[IRQ_W-1:0];
                default:    d.ctrl = q.ctrl;
            endcase
        end
        d.is = (clr_hit ? '0 : q.is) | irq_event;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl <= CTRL_RST;
            q.adv  <= ADV_RST;
            q.ie   <= '0;
            q.is   <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mgmt_serial_slave.sv
`timescale 1ns/1ps
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int          PRE_LEN  = 32,
    parameter int          IRQ_W    = 8,
    parameter logic [15:0] CTRL_RST = 16'h1100,
    parameter logic [15:0] ADV_RST  = 16'h01E1,
    parameter logic [15:0] ID_HI    = 16'h0022,
    parameter logic [15:0] ID_LO    = 16'h1615
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic [2:0]       strap_addr,
    input  logic [15:0]      phy_status,
    input  logic [15:0]      partner_ability,
    input  logic [IRQ_W-1:0] irq_event,
    output logic             irq
);
    logic              rd_req;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_req;
    logic [REG_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [IRQ_W-1:0]  irq_en;
    logic [IRQ_W-1:0]  irq_status;

    mgmt_frame_fsm #(
        .PRE_LEN(PRE_LEN)
    ) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_in   (mdio_in),
        .strap_addr(strap_addr),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    mgmt_reg_bank #(
        .IRQ_W   (IRQ_W),
        .CTRL_RST(CTRL_RST),
        .ADV_RST (ADV_RST),
        .ID_HI   (ID_HI),
        .ID_LO   (ID_LO)
    ) u_bank (
        .clk            (mdc),
        .rst_n          (rst_n),
        .rd_req         (rd_req),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .wr_req         (wr_req),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .phy_status     (phy_status),
        .partner_ability(partner_ability),
        .irq_event      (irq_event),
        .irq_en         (irq_en),
        .irq_status     (irq_status)
    );

    assign irq = |(irq_en & irq_status);
endmodule

// File: rtl/mgmt_slave_checker.sv
`timescale 1ns/1ps
module mgmt_slave_checker
    import mgmt_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdio_oe,
    input logic              mdio_out,
    input logic [2:0]        strap_addr,
    input logic              rd_req,
    input logic [REG_AW-1:0] rd_addr,
    input logic              wr_req,
    input logic [IRQ_W-1:0]  irq_event,
    input logic [IRQ_W-1:0]  irq_status,
    input logic              irq
);
    logic [5:0] oe_run;
    logic       clr_hit;

    assign clr_hit = rd_req && (rd_addr == REG_IRQ_ST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_run <= '0;
        else if (mdio_oe) oe_run <= (oe_run == 6'd63) ? oe_run : oe_run + 1'b1;
        else oe_run <= '0;
    end

    // R3: drive window never longer than 17 bit periods
    assert_oe_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= 6'd17);

    // R3: a closing drive window lasted exactly 17 bit periods
    assert_oe_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> oe_run == 6'd17);

    // R3: the first driven bit is the turnaround zero
    assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R6: a zero strap value keeps the line undriven
    assert_strap_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> strap_addr != 3'd0);

    // R10: status bits drop only after a read of the status register
    assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_status) & ~irq_status) != '0) |-> $past(clr_hit));

    // R9: interrupt rises only after an event or a register write
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_event) != '0) || $past(wr_req));
endmodule

bind mgmt_serial_slave mgmt_slave_checker #(.IRQ_W(IRQ_W)) u_chk (
    .clk       (mdc),
    .rst_n     (rst_n),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .strap_addr(strap_addr),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .wr_req    (wr_req),
    .irq_event (irq_event),
    .irq_status(irq_status),
    .irq       (irq)
);

// File: tb/sim_mgmt_serial_slave.sv
`timescale 1ns/1ps
module sim_mgmt_serial_slave;
    localparam int          IRQ_W = 8;
    localparam logic [15:0] C_RST = 16'h1100;
    localparam logic [15:0] A_RST = 16'h01E1;
    localparam logic [15:0] IDH   = 16'h0022;
    localparam logic [15:0] IDL   = 16'h1615;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             m_en = 1'b0;
    logic             m_bit = 1'b1;
    logic [2:0]       strap = 3'd5;
    logic [15:0]      phy_status = 16'h7809;
    logic [15:0]      partner = 16'h45E1;
    logic [IRQ_W-1:0] irq_event = '0;
    wire              mdio_out;
    wire              mdio_oe;
    wire              irq;
    wire              line = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

    int checks = 0;
    int fails  = 0;
    logic [15:0] ctrl_m;
    logic [15:0] adv_m;

    always #4 clk = ~clk;

    mgmt_serial_slave #(
        .PRE_LEN(32), .IRQ_W(IRQ_W), .CTRL_RST(C_RST), .ADV_RST(A_RST),
        .ID_HI(IDH), .ID_LO(IDL)
    ) u0 (
        .mdc(clk), .rst_n(rst_n), .mdio_in(line), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .strap_addr(strap), .phy_status(phy_status),
        .partner_ability(partner), .irq_event(irq_event), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        m_en  = 1'b1;
        m_bit = b;
    endtask

    task automatic header(input int pre, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra);
        send(1'b0);
        send(1'b0);
        repeat (pre) send(1'b1);
        send(1'b0);
        send(1'b1);
        for (int i = 1; i >= 0; i--) send(op[i]);
        for (int i = 4; i >= 0; i--) send(phy[i]);
        for (int i = 4; i >= 0; i--) send(ra[i]);
    endtask

    task automatic do_read(input int pre, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] data, output int oe_cnt,
                           output bit ta_ok);
        header(pre, op, phy, ra);
        @(negedge clk);
        m_en   = 1'b0;
        oe_cnt = int'(mdio_oe);
        data   = '0;
        @(negedge clk);
        ta_ok  = mdio_oe && !line;
        oe_cnt += int'(mdio_oe);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            data = {data[14:0], line};
            oe_cnt += int'(mdio_oe);
        end
        @(negedge clk);
        oe_cnt += int'(mdio_oe);
    endtask

    task automatic do_write(input int pre, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] data);
        header(pre, op, phy, ra);
        send(1'b1);
        send(1'b0);
        for (int i = 15; i >= 0; i--) send(data[i]);
        @(negedge clk);
        m_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] data);
        do_write(32, 2'b01, {2'b00, strap}, ra, data);
    endtask

    task automatic rd_expect(input logic [4:0] ra, input logic [15:0] exp,
                             input string tag);
        logic [15:0] d;
        int n;
        bit t;
        do_read(32, 2'b10, {2'b00, strap}, ra, d, n, t);
        chk(d == exp && n == 17 && t, tag, $sformatf("read reg %0d", ra), d, exp);
    endtask

    task automatic rd_silent(input int pre, input logic [1:0] op,
                             input logic [4:0] phy, input string tag);
        logic [15:0] d;
        int n;
        bit t;
        do_read(pre, op, phy, 5'd0, d, n, t);
        chk(n == 0, tag, $sformatf("drive cycles for addr %0d op %b", phy, op),
            16'(n), 16'd0);
    endtask

    task automatic pulse(input logic [IRQ_W-1:0] ev);
        @(negedge clk);
        irq_event = ev;
        @(negedge clk);
        irq_event = '0;
    endtask

    initial begin
        logic [15:0] pats [6];
        logic [15:0] d;
        int n;
        bit t;
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
        pats[3] = 16'h5A5A; pats[4] = 16'h0001; pats[5] = 16'h8000;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mdio_oe && !irq, "R1", "oe/irq in reset", {14'd0, mdio_oe, irq}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mdio_oe && !irq, "R1", "oe/irq after reset", {14'd0, mdio_oe, irq}, 16'd0);
        rd_expect(5'd0, C_RST, "R1");
        rd_expect(5'd4, A_RST, "R1");
        rd_expect(5'd22, 16'd0, "R1");
        rd_expect(5'd23, 16'd0, "R1");

        // R3: read timing in detail
        do_read(32, 2'b10, {2'b00, strap}, 5'd2, d, n, t);
        chk(n == 17, "R3", "drive window length", 16'(n), 16'd17);
        chk(t, "R3", "turnaround bit driven low", {15'd0, t}, 16'd1);
        chk(d == IDH, "R3", "data msb first", d, IDH);

        // R2: writable registers
        for (int p = 0; p < 6; p++) begin
            wr(5'd0, pats[p]);
            wr(5'd4, ~pats[p]);
            wr(5'd22, pats[p]);
            rd_expect(5'd0, pats[p], "R2");
            rd_expect(5'd4, ~pats[p], "R2");
            rd_expect(5'd22, pats[p] & 16'h00FF, "R2");
        end
        ctrl_m = pats[5];
        adv_m  = ~pats[5];
        wr(5'd22, 16'h0000);

        // R4: read-only registers
        rd_expect(5'd1, 16'h7809, "R4");
        rd_expect(5'd5, 16'h45E1, "R4");
        rd_expect(5'd2, IDH, "R4");
        rd_expect(5'd3, IDL, "R4");
        phy_status = 16'h1234;
        partner    = 16'hABCD;
        rd_expect(5'd1, 16'h1234, "R4");
        rd_expect(5'd5, 16'hABCD, "R4");
        wr(5'd1, 16'hFFFF);
        wr(5'd2, 16'hFFFF);
        wr(5'd3, 16'hFFFF);
        wr(5'd5, 16'hFFFF);
        rd_expect(5'd1, 16'h1234, "R4");
        rd_expect(5'd2, IDH, "R4");
        rd_expect(5'd3, IDL, "R4");
        rd_expect(5'd5, 16'hABCD, "R4");

        // R5: unimplemented addresses
        for (int a = 6; a < 32; a++) begin
            if (a != 22 && a != 23) begin
                wr(5'(a), 16'hBEEF);
                rd_expect(5'(a), 16'h0000, "R5");
            end
        end
        rd_expect(5'd0, ctrl_m, "R5");
        rd_expect(5'd4, adv_m, "R5");

        // R6: device address matching
        for (int a = 0; a < 32; a++) begin
            if (5'(a) != {2'b00, strap}) begin
                rd_silent(32, 2'b10, 5'(a), "R6");
                do_write(32, 2'b01, 5'(a), 5'd4, 16'h0F0F);
            end
        end
        rd_expect(5'd4, adv_m, "R6");
        strap = 3'd0;
        rd_silent(32, 2'b10, 5'd0, "R6");
        do_write(32, 2'b01, 5'd0, 5'd4, 16'h0F0F);
        strap = 3'd3;
        rd_expect(5'd4, adv_m, "R6");
        strap = 3'd5;

        // R7: invalid opcodes
        rd_silent(32, 2'b00, {2'b00, strap}, "R7");
        rd_silent(32, 2'b11, {2'b00, strap}, "R7");
        do_write(32, 2'b00, {2'b00, strap}, 5'd4, 16'h0F0F);
        do_write(32, 2'b11, {2'b00, strap}, 5'd4, 16'h0F0F);
        rd_expect(5'd4, adv_m, "R7");

        // R8: preamble length
        rd_silent(31, 2'b10, {2'b00, strap}, "R8");
        do_write(31, 2'b01, {2'b00, strap}, 5'd4, 16'h0F0F);
        rd_expect(5'd4, adv_m, "R8");
        do_read(40, 2'b10, {2'b00, strap}, 5'd4, d, n, t);
        chk(d == adv_m && n == 17, "R8", "long preamble read", d, adv_m);

        // R9: interrupt masking
        wr(5'd22, 16'h0005);
        pulse(8'h02);
        chk(!irq, "R9", "masked event", {15'd0, irq}, 16'd0);
        pulse(8'h04);
        chk(irq, "R9", "enabled event", {15'd0, irq}, 16'd1);
        // R10: clear on read
        rd_expect(5'd23, 16'h0006, "R10");
        chk(!irq, "R10", "irq after clear", {15'd0, irq}, 16'd0);
        rd_expect(5'd23, 16'h0000, "R10");

        // R9: latched event later enabled
        wr(5'd22, 16'h0000);
        pulse(8'h10);
        chk(!irq, "R9", "event with no enable", {15'd0, irq}, 16'd0);
        wr(5'd22, 16'h0010);
        chk(irq, "R9", "enable after event", {15'd0, irq}, 16'd1);
        rd_expect(5'd23, 16'h0010, "R10");

        // R9/R10: per-bit sweep
        for (int b = 0; b < IRQ_W; b++) begin
            wr(5'd22, 16'(1 << b));
            pulse(~IRQ_W'(1 << b));
            chk(!irq, "R9", $sformatf("other bits, enable bit %0d", b),
                {15'd0, irq}, 16'd0);
            pulse(IRQ_W'(1 << b));
            chk(irq, "R9", $sformatf("enabled bit %0d", b), {15'd0, irq}, 16'd1);
            rd_expect(5'd23, 16'h00FF, "R10");
            chk(!irq, "R10", $sformatf("cleared bit %0d", b), {15'd0, irq}, 16'd0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 16'd0, 16'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule